// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces all raster timing for a 256×192 bitmap display with a surrounding border. It runs on the CPU-cycle clock (one tick per T-state, nominally 3.5 MHz) and keeps a T-state counter within the line and a line counter within the frame. From these it derives horizontal and vertical sync and blanking, a display-active flag, a border-region flag, and a frame interrupt that is aligned to the start of every frame.

While the beam is in the bitmap window, the block issues a fetch strobe every 4 T-states. With each strobe it supplies the bitmap byte address, in the interleaved row layout, and the matching attribute byte address. A border colour written by the CPU is held back and takes effect only on the next 8-pixel (4 T-state) boundary. The raw counter values are exported so that CPU-side memory contention logic can use them.

Top module: `raster_timing`

## Requirements
- R1: The T-state counter `tstate_o` counts 0..223 and then returns to 0, so every line lasts exactly 224 T-states.
- R2: The line counter `line_o` advances by one when `tstate_o` wraps and counts 0..311 before returning to 0, so a frame is 69888 T-states.
- R3: `frame_irq` is high exactly when `line_o` is 0 and `tstate_o` is below 32, and low at all other times.
- R4: `disp_active` is high exactly when `line_o` is in 64..255 and `tstate_o` is in 0..127. This gives 64 lines ahead of the first display line, 192 display lines and 56 lines after them.
- R5: `hblank` is high for `tstate_o` in 152..199, which is the retrace between a 24 T-state right border and a 24 T-state left border. `hsync` is high for `tstate_o` in 160..191.
- R6: `vblank` is high for `line_o` in 0..15, and `vsync` is high for `line_o` in 4..7.
- R7: `border_active` is high exactly when none of `disp_active`, `hblank` and `vblank` is high.
- R8: `fetch_stb` is high exactly when `disp_active` is high and `tstate_o` is a multiple of 4.
- R9: With x = `tstate_o`/4 and y = `line_o`−64 during display, `bitmap_addr` = {3'b010, y[7:6], y[2:0], y[5:3], x[4:0]} and `attr_addr` = {6'b010110, y[7:3], x[4:0]}.
- R10: A value written on `border_din` while `border_we` is high is stored at that clock edge. `border_col` takes the most recent stored or written value only at the edge where `tstate_o` goes from a value ≡3 (mod 4) to the next value, so it changes only when `tstate_o` is a multiple of 4.
- R11: While `rst` is high at a clock edge, both counters and `border_col` (including the stored pending value) become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst | input | 1 | Synchronous reset, active high |
| border_we | input | 1 | Border colour write strobe |
| border_din | input | 3 | Border colour to write |
| tstate_o | output | 8 | T-state within the line |
| line_o | output | 9 | Line within the frame |
| hsync | output | 1 | Horizontal sync |
| hblank | output | 1 | Horizontal retrace blanking |
| vsync | output | 1 | Vertical sync |
| vblank | output | 1 | Vertical retrace blanking |
| disp_active | output | 1 | Beam inside the bitmap window |
| border_active | output | 1 | Beam inside the visible border |
| fetch_stb | output | 1 | Bitmap and attribute fetch strobe |
| bitmap_addr | output | 16 | Bitmap byte address |
| attr_addr | output | 16 | Attribute byte address |
| border_col | output | 3 | Border colour currently shown |
| frame_irq | output | 1 | Frame interrupt, 32 T-states wide |

## Verification
The counters run free for more than one full frame, including the wrap from line 311 to line 0. Every T-state of every line is therefore compared, and so are the top, display and bottom line regions and each horizontal region. Each line's sequence of bitmap addresses tells the interleaved row order apart from a linear one. Border writes come every 37 cycles, and 37 shares no factor with 4, so writes land on every phase of the 4 T-state group. This shows whether a write is applied at once or deferred to the next boundary. Two writes placed back to back inside one group check that only the last one is shown.

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int LINE_T    = 224,
  parameter int ACT_T     = 128,
  parameter int RBORD_T   = 24,
  parameter int HRET_T    = 48,
  parameter int HSYNC_DLY = 8,
  parameter int HSYNC_T   = 32,
  parameter int FRAME_L   = 312,
  parameter int TOP_L     = 64,
  parameter int DISP_L    = 192,
  parameter int VBLANK_L  = 16,
  parameter int VSYNC_DLY = 4,
  parameter int VSYNC_L   = 4,
  parameter int IRQ_T     = 32,
  localparam int TW = $clog2(LINE_T),
  localparam int LW = $clog2(FRAME_L)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          border_we,
  input  logic [2:0]    border_din,
  output logic [TW-1:0] tstate_o,
  output logic [LW-1:0] line_o,
  output logic          hsync,
  output logic          hblank,
  output logic          vsync,
  output logic          vblank,
  output logic          disp_active,
  output logic          border_active,
  output logic          fetch_stb,
  output logic [15:0]   bitmap_addr,
  output logic [15:0]   attr_addr,
  output logic [2:0]    border_col,
  output logic          frame_irq
);
  localparam logic [TW-1:0] T_LAST   = TW'(LINE_T - 1);
  localparam logic [TW-1:0] T_ACT    = TW'(ACT_T);
  localparam logic [TW-1:0] T_HB0    = TW'(ACT_T + RBORD_T);
  localparam logic [TW-1:0] T_HB1    = TW'(ACT_T + RBORD_T + HRET_T);
  localparam logic [TW-1:0] T_HS0    = TW'(ACT_T + RBORD_T + HSYNC_DLY);
  localparam logic [TW-1:0] T_HS1    = TW'(ACT_T + RBORD_T + HSYNC_DLY + HSYNC_T);
  localparam logic [TW-1:0] T_IRQ    = TW'(IRQ_T);
  localparam logic [LW-1:0] L_LAST   = LW'(FRAME_L - 1);
  localparam logic [LW-1:0] L_TOP    = LW'(TOP_L);
  localparam logic [LW-1:0] L_BOT    = LW'(TOP_L + DISP_L);
  localparam logic [LW-1:0] L_VB     = LW'(VBLANK_L);
  localparam logic [LW-1:0] L_VS0    = LW'(VSYNC_DLY);
  localparam logic [LW-1:0] L_VS1    = LW'(VSYNC_DLY + VSYNC_L);

  logic [TW-1:0] tcnt;
  logic [LW-1:0] lcnt;
  logic [2:0]    pend, col;
  logic          eol;

  assign eol = (tcnt == T_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt <= '0;
      lcnt <= '0;
    end else if (eol) begin
      tcnt <= '0;
      lcnt <= (lcnt == L_LAST) ? '0 : lcnt + 1'b1;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      col  <= '0;
    end else begin
      if (border_we) pend <= border_din;
      if (tcnt[1:0] == 2'b11) col <= border_we ? border_din : pend;
    end
  end

  logic [LW-1:0] yrow;
  logic [7:0]    y;
  logic [4:0]    x;
  assign yrow = lcnt - L_TOP;
  assign y    = yrow[7:0];
  assign x    = tcnt[6:2];

  assign tstate_o      = tcnt;
  assign line_o        = lcnt;
  assign hblank        = (tcnt >= T_HB0) && (tcnt < T_HB1);
  assign hsync         = (tcnt >= T_HS0) && (tcnt < T_HS1);
  assign vblank        = (lcnt < L_VB);
  assign vsync         = (lcnt >= L_VS0) && (lcnt < L_VS1);
  assign disp_active   = (lcnt >= L_TOP) && (lcnt < L_BOT) && (tcnt < T_ACT);
  assign border_active = !disp_active && !hblank && !vblank;
  assign fetch_stb     = disp_active && (tcnt[1:0] == 2'b00);
  assign bitmap_addr   = {3'b010, y[7:6], y[2:0], y[5:3], x};
  assign attr_addr     = {6'b010110, y[7:3], x};
  assign border_col    = col;
  assign frame_irq     = (lcnt == '0) && (tcnt < T_IRQ);

  a_r1_tstate_wrap: assert property (@(posedge clk) disable iff (rst)
    (tstate_o == T_LAST) |=> (tstate_o == '0));
  a_r2_line_step: assert property (@(posedge clk) disable iff (rst)
    (tstate_o == T_LAST && line_o != L_LAST) |=> (line_o == $past(line_o) + 1'b1));
  a_r2_line_hold: assert property (@(posedge clk) disable iff (rst)
    (tstate_o != T_LAST) |=> $stable(line_o));
  a_r3_irq_start: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_irq) |-> (line_o == '0 && tstate_o == '0));
  a_r7_regions_apart: assert property (@(posedge clk) disable iff (rst)
    disp_active |-> (!hblank && !vblank && !border_active));
  a_r10_col_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(border_col) |-> (tstate_o[1:0] == 2'b00));
endmodule

// File: tb/raster_timing_tb_top.sv
module raster_timing_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        border_we = 1'b0;
  logic [2:0]  border_din = 3'd0;
  logic [7:0]  tstate_o;
  logic [8:0]  line_o;
  logic        hsync, hblank, vsync, vblank, disp_active, border_active, fetch_stb, frame_irq;
  logic [15:0] bitmap_addr, attr_addr;
  logic [2:0]  border_col;

  int compared = 0, mismatched = 0;
  bit done = 0;
  int mt = 0, ml = 0, mpend = 0, mcol = 0;

  always #4 clk = ~clk;

  raster_timing dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s t=%0d l=%0d actual=%0d expected=%0d", req, mt, ml, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mt = 0; ml = 0; mpend = 0; mcol = 0;
    end else begin
      if (mt % 4 == 3) mcol = border_we ? int'(border_din) : mpend;
      if (border_we) mpend = border_din;
      mt++;
      if (mt == 224) begin
        mt = 0;
        ml = (ml == 311) ? 0 : ml + 1;
      end
    end
  end

  always @(negedge clk) if (!done) begin
    int eact, ey, ex, ebm, eat;
    eact = (ml >= 64 && ml < 256 && mt < 128) ? 1 : 0;
    ey = (ml - 64) & 255;
    ex = mt / 4;
    chk("R1 tstate", tstate_o, mt);
    chk("R2 line", line_o, ml);
    chk("R3 irq", frame_irq, (ml == 0 && mt < 32) ? 1 : 0);
    chk("R4 active", disp_active, eact);
    chk("R5 hblank", hblank, (mt >= 152 && mt < 200) ? 1 : 0);
    chk("R5 hsync", hsync, (mt >= 160 && mt < 192) ? 1 : 0);
    chk("R6 vblank", vblank, (ml < 16) ? 1 : 0);
    chk("R6 vsync", vsync, (ml >= 4 && ml < 8) ? 1 : 0);
    chk("R7 border", border_active,
        (eact == 0 && !(mt >= 152 && mt < 200) && ml >= 16) ? 1 : 0);
    chk("R8 fetch", fetch_stb, (eact == 1 && mt % 4 == 0) ? 1 : 0);
    chk("R10 col", border_col, mcol);
    if (eact == 1) begin
      ebm = 16'h4000 + (ey / 64) * 2048 + (ey % 8) * 256 + ((ey / 8) % 8) * 32 + ex;
      eat = 16'h5800 + (ey / 8) * 32 + ex;
      chk("R9 bitmap", bitmap_addr, ebm);
      chk("R9 attr", attr_addr, eat);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset tstate", tstate_o, 0);
    chk("R11 reset line", line_o, 0);
    chk("R11 reset col", border_col, 0);
    rst = 1'b0;
    for (int i = 0; i < 70600; i++) begin
      @(negedge clk);
      if (i % 37 == 5) begin
        border_we = 1'b1; border_din = 3'((i / 37) % 8);
      end else if (i == 1001 || i == 1002) begin
        border_we = 1'b1; border_din = (i == 1001) ? 3'd6 : 3'd1;
      end else begin
        border_we = 1'b0;
      end
    end
    border_we = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 midrun reset tstate", tstate_o, 0);
    chk("R11 midrun reset line", line_o, 0);
    chk("R11 midrun reset col", border_col, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(150000 * 8);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule